// File: doc/BRIEF.md
# Command Queue Mode and Trigger Controller

This block runs one command queue that hands conversion commands to converter buffers. Commands arrive through a valid/ready stream and wait in a small FIFO. Software selects one of three queue modes through a write/read register port: off, software-started single pass, or single pass started by a rising or falling edge on an external trigger pin. Once started, the queue sends its commands in order. Each command goes either to an internal buffer port (valid/ready) or out through a serial shifter toward an external buffer, and a transfer counter advances for every finished transfer.

Most of the logic deals with turning the queue off. A change of mode is accepted only while the queue is off and idle, or when the new mode is off. Turning the queue off mid-transfer finishes an internal hand-off but aborts a serial frame, unless the frame has already shifted out its abort-limit bit. Turning it off also drops the pass-request bit and re-arms the edge detector. It does not flush the FIFO, does not clear the counter and does not stop fill requests.

Command word layout: bit CMD_W-1 marks the last command of a pass and bit CMD_W-2 selects the target (1 = serial, 0 = internal). Register map: address 0 is control, with mode in [1:0] (0 off, 1 software, 2 rising edge, 3 falling edge), pass-request set in bit 2, flush in bit 3 and fill enable in bit 4. Address 1 is status, with running in bit 0, pass-request in bit 1 and FIFO empty in bit 2. Address 2 is the transfer counter. Back-pressure rules: a command is accepted on a cycle where both `cmd_valid` and `cmd_ready` are high. The internal port holds `int_data` steady while `int_valid` is high and `int_ready` is low.

Top module: `cq_queue_ctrl`

## Requirements
- R1: A control write whose mode field differs from the current mode is ignored when the current mode is not off and the new mode is not off; a new mode is taken when the current mode is off and the queue is idle, or when the new mode is off.
- R2: Switching the mode to off while running with no transfer under way makes the running bit read 0 one cycle later.
- R3: Switching to off while an internal hand-off is offered keeps `int_valid` up until `int_ready` accepts it. The counter then advances by one and the running bit drops in that same cycle.
- R4: Switching to off during a serial frame in which fewer than ABORT_AT (26) bit cycles have finished at that clock edge stops the frame. The counter does not advance, the queue goes idle, and the command remains in the FIFO.
- R5: Switching to off once ABORT_AT or more bit cycles of a serial frame have finished lets the frame complete. The counter then advances and the queue goes idle.
- R6: Turning the queue off leaves the FIFO contents in place. Writing 1 to the flush bit empties the FIFO only while the running bit is 0; a flush written while running is ignored.
- R7: The transfer counter is not cleared by turning the queue off. It advances by one per completed transfer, and a write of zero to it clears it.
- R8: Writing 1 to the pass-request bit sets status bit 1 when the resulting mode is not off, even if the same write moves the mode from off. The bit is cleared by a switch to off and by completion of the last command of a pass.
- R9: In the edge modes, the trigger passes through a two-flop synchroniser and only an edge of the selected polarity seen after the mode leaves off can start a pass. A level already present does not count, and an edge recorded before a switch to off is forgotten.
- R10: `fill_req` is high exactly when fill enable is set and the FIFO is not full, in every mode including off.
- R11: A pass sends the queued commands in FIFO order, each to the target selected by bit CMD_W-2, and returns to idle after the command carrying bit CMD_W-1.
- R12: While `int_valid` is high and `int_ready` is low, `int_valid` stays high and `int_data` stays unchanged.
- R13: A serial frame keeps `ser_frame` high for CMD_W cycles and sends the command word most significant bit first, one bit per cycle.
- R14: `cmd_ready` is high exactly when the FIFO is not full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready (FIFO not full) |
| cmd_data | input | CMD_W | Command word |
| fill_req | output | 1 | FIFO fill request |
| trig_in | input | 1 | Asynchronous external trigger |
| int_valid | output | 1 | Internal buffer command valid |
| int_ready | input | 1 | Internal buffer ready |
| int_data | output | CMD_W | Internal buffer command word |
| ser_frame | output | 1 | Serial frame active |
| ser_data | output | 1 | Serial data bit |
| q_busy | output | 1 | Queue running |

## Verification
The switch to off can land in the same cycle as the abort-limit bit of a serial frame. The bench provokes this by timing the disabling write from a live count of frame bits. With 25 finished bits the frame must be aborted and resent later. With 26 it must complete, count once, and only then go idle. A second collision is a single control write that both leaves the off mode and requests a pass. The pass-request bit is read back the next cycle, and the pass must then run to its end.

// File: rtl/cq_pkg.sv
package cq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SW   = 2'd1,
    MODE_RISE = 2'd2,
    MODE_FALL = 2'd3
  } cq_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cq_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_TCNT = 2'd2;

  // control field positions
  localparam int CTL_SSE  = 2;
  localparam int CTL_INV  = 3;
  localparam int CTL_FILL = 4;

  // status field positions
  localparam int STB_RUN   = 0;
  localparam int STB_SSS   = 1;
  localparam int STB_EMPTY = 2;

endpackage

// File: rtl/cq_fifo.sv
module cq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/cq_edge_det.sv
module cq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic clear,
  input  logic en,
  input  logic fall_sel,
  input  logic consume,
  output logic pend
);
  logic s1, s2, s3;
  logic hit;

  // s3 always follows s2, so a held level never reads as an edge
  assign hit = fall_sel ? (s3 && !s2) : (s2 && !s3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      s3   <= 1'b0;
      pend <= 1'b0;
    end else begin
      s1 <= trig;
      s2 <= s1;
      s3 <= s2;
      if (clear || consume) pend <= 1'b0;
      else if (en && hit)   pend <= 1'b1;
    end
  end
endmodule

// File: rtl/cq_ser_tx.sv
module cq_ser_tx #(
  parameter int W        = 32,
  parameter int ABORT_AT = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] word,
  input  logic         abort,
  output logic         busy,
  output logic         bit_o,
  output logic         done,
  output logic         aborted
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;

  // cnt = bit cycles finished before the current one
  assign done    = busy && (cnt == CW'(W - 1));
  assign aborted = abort && busy && (cnt < CW'(ABORT_AT - 1));
  assign bit_o   = busy && sh[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      sh   <= word;
      cnt  <= '0;
    end else if (busy) begin
      if (aborted || done) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        sh  <= {sh[W-2:0], 1'b0};
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cq_queue_ctrl.sv
module cq_queue_ctrl
  import cq_pkg::*;
#(
  parameter int CMD_W    = 32,
  parameter int DEPTH    = 8,
  parameter int CNT_W    = 8,
  parameter int ABORT_AT = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             fill_req,
  input  logic             trig_in,
  output logic             int_valid,
  input  logic             int_ready,
  output logic [CMD_W-1:0] int_data,
  output logic             ser_frame,
  output logic             ser_data,
  output logic             q_busy
);
  localparam int EOQ_BIT = CMD_W - 1;
  localparam int EXT_BIT = CMD_W - 2;

  cq_mode_e        mode_q, mode_nx, wr_mode;
  cq_state_e       state_q;
  logic            sss_q, fill_en_q, pend_q;
  logic [CNT_W-1:0] tcnt_q;

  logic             ctrl_wr, tcnt_wr, mode_ok, disable_now, sse_set, inv_ok;
  logic [CMD_W-1:0] head;
  logic             full, empty, head_ext, head_eoq;
  logic             ser_busy, ser_done, ser_aborted, ser_start;
  logic             int_done, xfer_done, active, start, edge_pend, edge_mode;

  // ---------------- register decode ----------------
  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign tcnt_wr = wr_en && (wr_addr == ADDR_TCNT);
  assign wr_mode = cq_mode_e'(wr_data[1:0]);

  assign mode_ok = ((mode_q == MODE_OFF) && (state_q == ST_IDLE)) ||
                   (wr_mode == MODE_OFF) || (wr_mode == mode_q);
  assign mode_nx = (ctrl_wr && mode_ok) ? wr_mode : mode_q;

  assign disable_now = ctrl_wr && (mode_q != MODE_OFF) && (wr_mode == MODE_OFF);
  assign sse_set     = ctrl_wr && wr_data[CTL_SSE] && (mode_nx != MODE_OFF);
  assign inv_ok      = ctrl_wr && wr_data[CTL_INV] && (state_q == ST_IDLE);

  // ---------------- command FIFO ----------------
  cq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (cmd_valid),
    .din   (cmd_data),
    .pop   (xfer_done),
    .flush (inv_ok),
    .head  (head),
    .full  (full),
    .empty (empty)
  );

  assign cmd_ready = !full;
  assign fill_req  = fill_en_q && !full;
  assign head_ext  = head[EXT_BIT];
  assign head_eoq  = head[EOQ_BIT];

  // ---------------- trigger ----------------
  assign edge_mode = (mode_q == MODE_RISE) || (mode_q == MODE_FALL);

  cq_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig_in),
    .clear    (mode_q == MODE_OFF),
    .en       (edge_mode && (state_q == ST_IDLE)),
    .fall_sel (mode_q == MODE_FALL),
    .consume  (start),
    .pend     (edge_pend)
  );

  assign start = (state_q == ST_IDLE) && !disable_now && sss_q &&
                 ((mode_q == MODE_SW) || (edge_mode && edge_pend));

  // ---------------- transfer issue ----------------
  assign int_valid = (state_q == ST_RUN) && !empty && !head_ext && !ser_busy;
  assign int_data  = head;
  assign int_done  = int_valid && int_ready;
  assign ser_start = (state_q == ST_RUN) && !pend_q && !disable_now &&
                     !empty && head_ext && !ser_busy;

  cq_ser_tx #(.W(CMD_W), .ABORT_AT(ABORT_AT)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (ser_start),
    .word    (head),
    .abort   (disable_now),
    .busy    (ser_busy),
    .bit_o   (ser_data),
    .done    (ser_done),
    .aborted (ser_aborted)
  );

  assign ser_frame = ser_busy;
  assign xfer_done = int_done || ser_done;
  assign active    = int_valid || ser_busy;
  assign q_busy    = (state_q == ST_RUN);

  // ---------------- control state ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_OFF;
      state_q   <= ST_IDLE;
      sss_q     <= 1'b0;
      fill_en_q <= 1'b0;
      pend_q    <= 1'b0;
      tcnt_q    <= '0;
    end else begin
      mode_q <= mode_nx;
      if (ctrl_wr) fill_en_q <= wr_data[CTL_FILL];

      if (ctrl_wr && (mode_nx == MODE_OFF)) sss_q <= 1'b0;
      else if (sse_set)                      sss_q <= 1'b1;
      else if (xfer_done && head_eoq)        sss_q <= 1'b0;

      if (tcnt_wr)        tcnt_q <= wr_data;
      else if (xfer_done) tcnt_q <= tcnt_q + 1'b1;

      if (state_q == ST_RUN) begin
        if (xfer_done && (head_eoq || pend_q || disable_now)) begin
          state_q <= ST_IDLE;
          pend_q  <= 1'b0;
        end else if (disable_now) begin
          if (ser_aborted || !active) state_q <= ST_IDLE;
          else                        pend_q  <= 1'b1;
        end
      end else if (start) begin
        state_q <= ST_RUN;
      end
    end
  end

  // ---------------- register read ----------------
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTRL: begin
        rd_data[1:0]     = mode_q;
        rd_data[CTL_FILL] = fill_en_q;
      end
      ADDR_STAT: begin
        rd_data[STB_RUN]   = (state_q == ST_RUN);
        rd_data[STB_SSS]   = sss_q;
        rd_data[STB_EMPTY] = empty;
      end
      ADDR_TCNT: rd_data = tcnt_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cq_queue_ctrl_chk.sv
module cq_queue_ctrl_chk #(
  parameter int CMD_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input logic [1:0]       wr_mode,
  input logic [1:0]       mode_q,
  input logic             disable_now,
  input logic             active,
  input logic             q_busy,
  input logic             int_valid,
  input logic             int_ready,
  input logic [CMD_W-1:0] int_data,
  input logic             sss_q,
  input logic             ser_frame,
  input logic             ser_aborted,
  input logic             fill_req,
  input logic             cmd_ready
);
  p_mode_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (mode_q != 2'd0) && (wr_mode != 2'd0) && (wr_mode != mode_q))
      |=> (mode_q == $past(mode_q)));

  p_quiet_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (disable_now && !active) |=> !q_busy);

  p_abort_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_aborted |=> (!ser_frame && !q_busy));

  p_sss_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disable_now |=> !sss_q);

  p_fill_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> cmd_ready);

  p_int_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && !int_ready) |=> (int_valid && $stable(int_data)));
endmodule

bind cq_queue_ctrl cq_queue_ctrl_chk #(.CMD_W(CMD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrl_wr     (ctrl_wr),
  .wr_mode     (wr_mode),
  .mode_q      (mode_q),
  .disable_now (disable_now),
  .active      (active),
  .q_busy      (q_busy),
  .int_valid   (int_valid),
  .int_ready   (int_ready),
  .int_data    (int_data),
  .sss_q       (sss_q),
  .ser_frame   (ser_frame),
  .ser_aborted (ser_aborted),
  .fill_req    (fill_req),
  .cmd_ready   (cmd_ready)
);

// File: tb/tb_cq_queue_ctrl.sv
module tb_cq_queue_ctrl;
  localparam int CMD_W = 32;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [1:0]       rd_addr = '0;
  logic [CNT_W-1:0] rd_data;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [CMD_W-1:0] cmd_data = '0;
  logic             fill_req;
  logic             trig_in = 1'b0;
  logic             int_valid;
  logic             int_ready = 1'b0;
  logic [CMD_W-1:0] int_data;
  logic             ser_frame, ser_data, q_busy;

  cq_queue_ctrl dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int scnt = 0;
  int aborts = 0;
  logic [CMD_W-1:0] sbits = '0;
  logic [CMD_W-1:0] exp_q[$];
  logic [CNT_W-1:0] r;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // driver: pushes a command and, if it should be delivered, its expectation
  task automatic push(input logic [CMD_W-1:0] w, input bit expect_out);
    cmd_valid = 1'b1; cmd_data = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (expect_out) exp_q.push_back(w);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q_busy);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // monitor: samples just before each rising edge
  always begin
    @(negedge clk);
    #9;
    if (rst_n) begin
      if (int_valid && int_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R11 unexpected internal", int_data, '0);
        else begin
          logic [CMD_W-1:0] e;
          e = exp_q.pop_front();
          chk(int_data == e, "R11 internal order", int_data, e);
        end
      end
      if (ser_frame) begin
        sbits = {sbits[CMD_W-2:0], ser_data};
        scnt++;
        if (scnt == CMD_W) begin
          scnt = 0;
          if (exp_q.size() == 0) chk(1'b0, "R13 unexpected frame", sbits, '0);
          else begin
            logic [CMD_W-1:0] e;
            e = exp_q.pop_front();
            chk(sbits == e, "R13 serial word", sbits, e);
          end
        end
      end else if (scnt != 0) begin
        aborts++;
        scnt = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(0, r); chk(r == 0, "R1 reset ctrl", r, 0);
    rd(1, r); chk(r == 8'h04, "R6 reset status", r, 8'h04);
    rd(2, r); chk(r == 0, "R7 reset counter", r, 0);
    chk(fill_req == 0, "R10 reset fill_req", fill_req, 0);
    chk(cmd_ready == 1, "R14 reset cmd_ready", cmd_ready, 1);

    // fill request with the queue off
    wr(0, 8'h10);
    chk(fill_req == 1, "R10 fill while off", fill_req, 1);
    for (int i = 0; i < 8; i++) push(32'h0000_1000 + i, 1'b0);
    chk(fill_req == 0, "R10 fill stops when full", fill_req, 0);
    chk(cmd_ready == 0, "R14 not ready when full", cmd_ready, 0);
    wr(0, 8'h18);
    rd(1, r); chk(r[2] == 1, "R6 flush while idle", r[2], 1);
    chk(fill_req == 1, "R10 fill after flush", fill_req, 1);
    wr(0, 8'h00);
    chk(fill_req == 0, "R10 fill enable cleared", fill_req, 0);

    // software single pass, mixed targets, back-pressure
    push(32'h0000_00A1, 1'b1);
    push(32'h4000_B00B, 1'b1);
    push(32'h8000_0C0C, 1'b1);
    wr(0, 8'h05);
    rd(1, r); chk(r[1] == 1, "R8 request set with mode change", r[1], 1);
    @(negedge clk); @(negedge clk);
    chk(int_valid == 1 && int_data == 32'h0000_00A1, "R12 first offer", int_data, 32'h0000_00A1);
    wr(0, 8'h02);
    rd(0, r); chk(r[1:0] == 1, "R1 change while running ignored", r[1:0], 1);
    @(negedge clk);
    chk(int_valid == 1 && int_data == 32'h0000_00A1, "R12 held under back-pressure", int_data, 32'h0000_00A1);
    int_ready = 1'b1;
    wait_idle();
    rd(2, r); chk(r == 3, "R7 counter after pass", r, 3);
    rd(1, r); chk(r[1] == 0, "R8 request cleared at pass end", r[1], 0);
    chk(exp_q.size() == 0, "R11 pass delivered all", exp_q.size(), 0);
    wr(0, 8'h03);
    rd(0, r); chk(r[1:0] == 1, "R1 change while idle and on ignored", r[1:0], 1);
    wr(0, 8'h00);

    // off with nothing in flight
    wr(0, 8'h05);
    @(negedge clk);
    chk(q_busy == 1, "R2 running on empty queue", q_busy, 1);
    wr(0, 8'h00);
    chk(q_busy == 0, "R2 idle one cycle after off", q_busy, 0);
    rd(2, r); chk(r == 3, "R7 counter kept across off", r, 3);
    wr(2, 8'h00);
    rd(2, r); chk(r == 0, "R7 counter cleared by zero write", r, 0);

    // rising edge mode: present level does not count
    trig_in = 1'b1;
    repeat (4) @(negedge clk);
    push(32'h8000_0D0D, 1'b1);
    wr(0, 8'h06);
    repeat (8) @(negedge clk);
    chk(q_busy == 0, "R9 held level ignored", q_busy, 0);
    trig_in = 1'b0; repeat (3) @(negedge clk);
    trig_in = 1'b1; repeat (12) @(negedge clk);
    rd(2, r); chk(r == 1, "R9 rising edge starts pass", r, 1);

    // edge seen before off is forgotten
    push(32'h8000_0E0E, 1'b1);
    trig_in = 1'b0; repeat (3) @(negedge clk);
    trig_in = 1'b1; repeat (5) @(negedge clk);
    chk(q_busy == 0, "R9 edge without request", q_busy, 0);
    wr(0, 8'h00);
    wr(0, 8'h06);
    repeat (8) @(negedge clk);
    chk(q_busy == 0 && dut.q_busy == 0, "R9 re-armed after off", q_busy, 0);
    rd(2, r); chk(r == 1, "R9 no transfer after re-arm", r, 1);
    trig_in = 1'b0; repeat (3) @(negedge clk);
    trig_in = 1'b1; repeat (12) @(negedge clk);
    rd(2, r); chk(r == 2, "R9 fresh edge starts pass", r, 2);

    // falling edge mode
    wr(0, 8'h00);
    push(32'h8000_0F0F, 1'b1);
    wr(0, 8'h07);
    repeat (6) @(negedge clk);
    chk(q_busy == 0, "R9 high level in falling mode", q_busy, 0);
    trig_in = 1'b0; repeat (12) @(negedge clk);
    rd(2, r); chk(r == 3, "R9 falling edge starts pass", r, 3);

    // off while an internal hand-off is offered
    wr(0, 8'h00);
    wr(2, 8'h00);
    int_ready = 1'b0;
    push(32'h0000_0A0A, 1'b1);
    push(32'h8000_0B0B, 1'b0);
    wr(0, 8'h05);
    @(negedge clk); @(negedge clk);
    chk(int_valid == 1, "R3 offer pending", int_valid, 1);
    wr(0, 8'h00);
    chk(q_busy == 1, "R3 stays running until accepted", q_busy, 1);
    rd(1, r); chk(r[1] == 0, "R8 request cleared by off", r[1], 0);
    rd(0, r); chk(r[1:0] == 0, "R1 off taken at once", r[1:0], 0);
    @(negedge clk);
    chk(int_valid == 1, "R3 offer kept", int_valid, 1);
    int_ready = 1'b1;
    @(negedge clk);
    int_ready = 1'b0;
    chk(q_busy == 0, "R3 idle after accept", q_busy, 0);
    rd(2, r); chk(r == 1, "R3 counted once", r, 1);
    rd(1, r); chk(r[2] == 0, "R6 off leaves FIFO", r[2], 0);

    // flush while running is ignored
    wr(0, 8'h05);
    @(negedge clk); @(negedge clk);
    wr(0, 8'h0D);
    rd(1, r); chk(r[2] == 0, "R6 flush while running ignored", r[2], 0);
    exp_q.push_back(32'h8000_0B0B);
    int_ready = 1'b1;
    wait_idle();
    int_ready = 1'b0;
    rd(2, r); chk(r == 2, "R11 second pass counted", r, 2);

    // serial off after 25 bits: abort
    wr(0, 8'h00);
    wr(2, 8'h00);
    push(32'hC3A5_5A3C, 1'b0);
    wr(0, 8'h05);
    while (scnt != 24) @(negedge clk);
    wr(0, 8'h00);
    @(negedge clk);
    chk(aborts == 1, "R4 frame stopped", aborts, 1);
    chk(q_busy == 0, "R4 idle after abort", q_busy, 0);
    rd(2, r); chk(r == 0, "R4 no count on abort", r, 0);
    rd(1, r); chk(r[2] == 0, "R4 command kept", r[2], 0);
    exp_q.push_back(32'hC3A5_5A3C);
    wr(0, 8'h05);
    wait_idle();
    rd(2, r); chk(r == 1, "R13 resent frame counted", r, 1);

    // serial off after 26 bits: complete
    wr(0, 8'h00);
    wr(2, 8'h00);
    push(32'hE1F0_0F1E, 1'b1);
    wr(0, 8'h05);
    while (scnt != 25) @(negedge clk);
    wr(0, 8'h00);
    chk(q_busy == 1 && ser_frame == 1, "R5 frame continues", {q_busy, ser_frame}, 2'b11);
    wait_idle();
    @(negedge clk);
    rd(2, r); chk(r == 1, "R5 late off counted", r, 1);
    chk(aborts == 1, "R5 no extra abort", aborts, 1);
    rd(1, r); chk(r[2] == 1, "R5 FIFO drained", r[2], 1);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 scoreboard empty", exp_q.size(), 0);
    finish_run();
  end
endmodule